// File: doc/BRIEF.md
# I/O Port Decoder with Per-Slot Wait Stretching

This block sits beside an 8-bit CPU and turns each I/O cycle's port number into select lines. The lower half of the 256-port space is divided into four equal windows, one per expansion slot, and each window drives an active-low slot select. The upper half is kept for on-board functions: a serial-port window with an active-low select, a serial-flash master window and a memory-paging window with active-high selects, and a window that holds the block's own wait configuration.

Each slot has a 2-bit, CPU-readable and CPU-writable setting that gives how many extra wait states (0, 1 or 2) to add to I/O cycles aimed at that slot. A setting of 3 counts as 2. The block pulls its active-low wait output from the first clock of a qualifying I/O cycle and holds it for that many clocks. Memory cycles, interrupt-acknowledge cycles, on-board windows and the serial port never get wait states. The CPU clock is the block's only clock. In the target system it is half of a faster board oscillator.

Top module: `io_slot_decoder`

## Requirements
- R1: An I/O cycle (iorq_ni low, m1_ni high) to a port below 0x80 pulls slot_sel_no[k] low, where k is port bits 6:5. All other slot selects stay high. Ports 0x80 and above pull no slot select.
- R2: In an I/O cycle, uart_sel_no is low for ports 0x80–0x9F, spi_sel_o is high for 0xA0–0xBF and page_sel_o is high for 0xE0–0xFF. Ports 0xC0–0xDF drive none of these.
- R3: When iorq_ni and m1_ni are both low (interrupt acknowledge), every select is inactive, wait_no is high, data_oe_o is low and no configuration register changes.
- R4: An I/O cycle with wr_ni low to port 0xC0+k (k = 0..3) stores data_i[1:0] as slot k's wait setting. Writes to 0xC4–0xDF change nothing.
- R5: An I/O cycle with rd_ni low to port 0xC0+k sets data_oe_o high and drives data_o = {6'b0, setting k}. In every other case data_oe_o is low and data_o is 0.
- R6: After reset, all four settings read as 2.
- R7: In an I/O cycle to slot k, wait_no is low from the first clock of the cycle for exactly min(setting k, 2) clocks and then goes high. A setting of 0 adds no wait, and a setting of 3 behaves as 2.
- R8: wait_no stays high for memory cycles (iorq_ni high), for on-board windows and for the serial port.
- R9: wait_no returns high as soon as iorq_ni goes high. Every new I/O cycle starts its wait count from zero.
- R10: At most one of the slot, serial-port, flash-master and paging selects is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Port number (address low byte) |
| iorq_ni | input | 1 | I/O request, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| m1_ni | input | 1 | Opcode fetch / acknowledge marker, active low |
| data_i | input | 8 | CPU write data |
| data_o | output | 8 | Configuration read data |
| data_oe_o | output | 1 | Read data enable |
| slot_sel_no | output | 4 | Expansion slot selects, active low |
| uart_sel_no | output | 1 | Serial port select, active low |
| spi_sel_o | output | 1 | Serial-flash master select |
| page_sel_o | output | 1 | Paging unit select |
| wait_no | output | 1 | Wait request to CPU, active low |

## Verification
The assertions expect the port number and the strobes to stay stable through each clock of an I/O cycle. They also expect iorq_ni to go high between two cycles, because the wait bound counts consecutive low clocks on wait_no. The bench changes its inputs only at falling edges. Every I/O cycle it issues ends with at least one idle clock, and interrupt-acknowledge cycles are driven with m1_ni held low for the whole cycle. These choices keep the stimulus inside the conditions the assertions assume.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam int SLOTS    = 4;
  localparam int CFG_W    = 2;
  localparam int MAX_WAIT = 2;
  localparam int RST_WAIT = 2;

  // upper-half window order is fixed by the port map
  typedef enum logic [1:0] {
    WIN_UART = 2'd0,
    WIN_SPI  = 2'd1,
    WIN_CFG  = 2'd2,
    WIN_PAGE = 2'd3
  } int_win_e;

  function automatic logic [CFG_W-1:0] clamp_wait(logic [CFG_W-1:0] raw);
    return (raw > CFG_W'(MAX_WAIT)) ? CFG_W'(MAX_WAIT) : raw;
  endfunction
endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode #(
  parameter int ADDR_W = io_dec_pkg::ADDR_W,
  parameter int SLOTS  = io_dec_pkg::SLOTS,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_cycle_i,
  output logic [SLOTS-1:0]  slot_hit_o,
  output logic              uart_hit_o,
  output logic              spi_hit_o,
  output logic              cfg_hit_o,
  output logic              page_hit_o
);
  import io_dec_pkg::*;

  logic             upper;
  logic [IDX_W-1:0] win;

  assign upper = addr_i[ADDR_W-1];
  assign win   = addr_i[ADDR_W-2 -: IDX_W];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign slot_hit_o[k] = io_cycle_i && !upper && (win == IDX_W'(k));
  end

  assign uart_hit_o = io_cycle_i && upper && (win == IDX_W'(WIN_UART));
  assign spi_hit_o  = io_cycle_i && upper && (win == IDX_W'(WIN_SPI));
  assign cfg_hit_o  = io_cycle_i && upper && (win == IDX_W'(WIN_CFG));
  assign page_hit_o = io_cycle_i && upper && (win == IDX_W'(WIN_PAGE));
endmodule

// File: rtl/io_wait_cfg.sv
module io_wait_cfg #(
  parameter int ADDR_W = io_dec_pkg::ADDR_W,
  parameter int DATA_W = io_dec_pkg::DATA_W,
  parameter int SLOTS  = io_dec_pkg::SLOTS,
  parameter int CFG_W  = io_dec_pkg::CFG_W,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int WIN_W = ADDR_W - 1 - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_hit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  slot_idx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [CFG_W-1:0]  wait_len_o
);
  import io_dec_pkg::*;

  logic [CFG_W-1:0] cfg_q [SLOTS];
  logic             reg_hit;
  logic [IDX_W-1:0] reg_idx;

  // only the first SLOTS ports of the window are registers
  assign reg_hit = cfg_hit_i && (addr_i[WIN_W-1:IDX_W] == '0);
  assign reg_idx = addr_i[IDX_W-1:0];

  for (genvar k = 0; k < SLOTS; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cfg_q[k] <= CFG_W'(RST_WAIT);
      else if (reg_hit && !wr_ni && reg_idx == IDX_W'(k))
        cfg_q[k] <= data_i[CFG_W-1:0];
    end
  end

  assign data_oe_o  = reg_hit && !rd_ni;
  assign data_o     = data_oe_o ? DATA_W'(cfg_q[reg_idx]) : '0;
  assign wait_len_o = clamp_wait(cfg_q[slot_idx_i]);
endmodule

// File: rtl/io_wait_timer.sv
module io_wait_timer #(
  parameter int CFG_W = io_dec_pkg::CFG_W,
  parameter int MAX_WAIT = io_dec_pkg::MAX_WAIT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             io_cycle_i,
  input  logic             slot_any_i,
  input  logic [CFG_W-1:0] wait_len_i,
  output logic             wait_no
);
  logic [CFG_W-1:0] elapsed_q;

  // clocks spent in the current I/O cycle, cleared between cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      elapsed_q <= '0;
    else if (!io_cycle_i)
      elapsed_q <= '0;
    else if (elapsed_q < CFG_W'(MAX_WAIT))
      elapsed_q <= elapsed_q + 1'b1;
  end

  assign wait_no = !(io_cycle_i && slot_any_i && (elapsed_q < wait_len_i));
endmodule

// File: rtl/io_slot_decoder.sv
module io_slot_decoder #(
  parameter int ADDR_W   = io_dec_pkg::ADDR_W,
  parameter int DATA_W   = io_dec_pkg::DATA_W,
  parameter int SLOTS    = io_dec_pkg::SLOTS,
  parameter int CFG_W    = io_dec_pkg::CFG_W,
  parameter int MAX_WAIT = io_dec_pkg::MAX_WAIT,
  localparam int IDX_W   = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              iorq_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              m1_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [SLOTS-1:0]  slot_sel_no,
  output logic              uart_sel_no,
  output logic              spi_sel_o,
  output logic              page_sel_o,
  output logic              wait_no
);
  logic             io_cycle;
  logic [SLOTS-1:0] slot_hit;
  logic             uart_hit, cfg_hit;
  logic [CFG_W-1:0] wait_len;

  // acknowledge cycles (iorq with m1) are not port accesses
  assign io_cycle = !iorq_ni && m1_ni;

  io_addr_decode #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_dec (
    .addr_i    (addr_i),
    .io_cycle_i(io_cycle),
    .slot_hit_o(slot_hit),
    .uart_hit_o(uart_hit),
    .spi_hit_o (spi_sel_o),
    .cfg_hit_o (cfg_hit),
    .page_hit_o(page_sel_o)
  );

  io_wait_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS), .CFG_W(CFG_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_hit_i (cfg_hit),
    .addr_i    (addr_i),
    .rd_ni     (rd_ni),
    .wr_ni     (wr_ni),
    .data_i    (data_i),
    .slot_idx_i(addr_i[ADDR_W-2 -: IDX_W]),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .wait_len_o(wait_len)
  );

  io_wait_timer #(.CFG_W(CFG_W), .MAX_WAIT(MAX_WAIT)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .io_cycle_i(io_cycle),
    .slot_any_i(|slot_hit),
    .wait_len_i(wait_len),
    .wait_no   (wait_no)
  );

  assign slot_sel_no = ~slot_hit;
  assign uart_sel_no = !uart_hit;
endmodule

// File: rtl/io_slot_decoder_chk.sv
module io_slot_decoder_chk #(
  parameter int ADDR_W   = 8,
  parameter int SLOTS    = 4,
  parameter int MAX_WAIT = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              iorq_ni,
  input logic              rd_ni,
  input logic              m1_ni,
  input logic              data_oe_o,
  input logic [SLOTS-1:0]  slot_sel_no,
  input logic              uart_sel_no,
  input logic              spi_sel_o,
  input logic              page_sel_o,
  input logic              wait_no
);
  logic [7:0] wait_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             wait_run <= '0;
    else if (wait_no)        wait_run <= '0;
    else if (wait_run != '1) wait_run <= wait_run + 1'b1;
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~slot_sel_no, ~uart_sel_no, spi_sel_o, page_sel_o})); // R10
  AST_INTA_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iorq_ni && !m1_ni) |-> (&slot_sel_no && uart_sel_no && !spi_sel_o &&
                              !page_sel_o && wait_no && !data_oe_o)); // R3
  AST_UPPER_NO_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i[ADDR_W-1] |-> &slot_sel_no); // R1
  AST_WAIT_SLOT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &slot_sel_no |-> wait_no); // R8
  AST_IDLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iorq_ni |-> wait_no); // R9
  AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wait_no |-> (wait_run < 8'(MAX_WAIT))); // R7
  AST_OE_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!iorq_ni && m1_ni && !rd_ni && addr_i[ADDR_W-1])); // R5
endmodule

bind io_slot_decoder io_slot_decoder_chk #(
  .ADDR_W(ADDR_W), .SLOTS(SLOTS), .MAX_WAIT(MAX_WAIT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .iorq_ni    (iorq_ni),
  .rd_ni      (rd_ni),
  .m1_ni      (m1_ni),
  .data_oe_o  (data_oe_o),
  .slot_sel_no(slot_sel_no),
  .uart_sel_no(uart_sel_no),
  .spi_sel_o  (spi_sel_o),
  .page_sel_o (page_sel_o),
  .wait_no    (wait_no)
);

// File: tb/io_slot_decoder_test.sv
module io_slot_decoder_test;
  logic       clk_i = 0, rst_ni = 0;
  logic [7:0] addr_i = 0, data_i = 0;
  logic       iorq_ni = 1, rd_ni = 1, wr_ni = 1, m1_ni = 1;
  logic [7:0] data_o;
  logic       data_oe_o, uart_sel_no, spi_sel_o, page_sel_o, wait_no;
  logic [3:0] slot_sel_no;

  int cfg_m[4];
  int elapsed_m;
  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  io_slot_decoder uut (.*);

  // behavioural reference state
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < 4; k++) cfg_m[k] = 2;
      elapsed_m = 0;
    end else begin
      if (!iorq_ni && m1_ni && !wr_ni && addr_i >= 8'hC0 && addr_i <= 8'hC3)
        cfg_m[addr_i - 8'hC0] = int'(data_i) & 3;
      if (!(!iorq_ni && m1_ni)) elapsed_m = 0;
      else elapsed_m = elapsed_m + 1;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s addr=%02h actual=%0d expected=%0d", tag, what, addr_i, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    bit io;
    int eff, e_slot, e_wait, e_oe, e_dat;
    io = !iorq_ni && m1_ni;
    e_slot = (io && addr_i < 8'h80) ? (~(1 << (addr_i >> 5))) & 15 : 15;
    eff = 0;
    if (io && addr_i < 8'h80) eff = (cfg_m[addr_i >> 5] > 2) ? 2 : cfg_m[addr_i >> 5];
    e_wait = (elapsed_m < eff) ? 0 : 1;
    e_oe = (io && !rd_ni && addr_i >= 8'hC0 && addr_i <= 8'hC3) ? 1 : 0;
    e_dat = e_oe ? cfg_m[addr_i - 8'hC0] : 0;
    chk(tag, "slot_sel_no", int'(slot_sel_no), e_slot);
    chk(tag, "uart_sel_no", int'(uart_sel_no), (io && addr_i[7:5] == 3'd4) ? 0 : 1);
    chk(tag, "spi_sel_o", int'(spi_sel_o), (io && addr_i[7:5] == 3'd5) ? 1 : 0);
    chk(tag, "page_sel_o", int'(page_sel_o), (io && addr_i[7:5] == 3'd7) ? 1 : 0);
    chk(tag, "wait_no", int'(wait_no), e_wait);
    chk(tag, "data_oe_o", int'(data_oe_o), e_oe);
    chk(tag, "data_o", int'(data_o), e_dat);
  endtask

  task automatic drive(bit iorq, bit m1, bit rd, bit wr, int a, int d, string tag);
    @(negedge clk_i);
    iorq_ni = iorq; m1_ni = m1; rd_ni = rd; wr_ni = wr;
    addr_i = 8'(a); data_i = 8'(d);
    #1 check_all(tag);
  endtask

  task automatic idle(string tag);
    drive(1, 1, 1, 1, int'(addr_i), 0, tag);
  endtask

  task automatic io_rd(int a, int cyc, string tag);
    for (int c = 0; c < cyc; c++) drive(0, 1, 0, 1, a, 0, tag);
    idle(tag);
  endtask

  task automatic io_wr(int a, int d, string tag);
    drive(0, 1, 1, 0, a, d, tag);
    drive(0, 1, 1, 0, a, d, tag);
    idle(tag);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2 check_all("R6_reset");
    #20 rst_ni = 1;
    idle("R8_idle");
    // R6: power-on settings
    for (int k = 0; k < 4; k++) io_rd(8'hC0 + k, 1, "R6");
    // R7: default two waits on every slot
    for (int k = 0; k < 4; k++) io_rd(k * 32 + 5, 4, "R7_default");
    // R4: program 0,1,3,2
    io_wr(8'hC0, 8'hFC, "R4");
    io_wr(8'hC1, 8'h01, "R4");
    io_wr(8'hC2, 8'h03, "R4");
    io_wr(8'hC3, 8'h02, "R4");
    for (int k = 0; k < 4; k++) io_rd(8'hC0 + k, 1, "R5");
    for (int k = 0; k < 4; k++) io_rd(k * 32 + 31, 4, "R7");
    // R4: writes above the register ports are ignored
    io_wr(8'hC4, 8'h00, "R4_ignored");
    io_wr(8'hDF, 8'h00, "R4_ignored");
    io_rd(8'hC4, 1, "R5_noreg");
    for (int k = 0; k < 4; k++) io_rd(8'hC0 + k, 1, "R4_ignored");
    // R2/R8: on-board windows never wait
    io_rd(8'h80, 3, "R2");
    io_rd(8'hA0, 3, "R2");
    io_rd(8'hC7, 3, "R2");
    io_rd(8'hE0, 3, "R2");
    io_rd(8'hFF, 3, "R8");
    // R3: interrupt acknowledge with slot address and write strobe
    for (int c = 0; c < 3; c++) drive(0, 0, 1, 0, 8'hC1, 8'h00, "R3");
    idle("R3");
    io_rd(8'hC1, 1, "R3");
    // R9: early release and restart
    drive(0, 1, 0, 1, 8'h60, 0, "R9");
    drive(1, 1, 1, 1, 8'h60, 0, "R9");
    io_rd(8'h60, 3, "R9");
    // R8: memory cycle on a slot address
    for (int c = 0; c < 3; c++) drive(1, 0, 0, 1, 8'h20, 0, "R8");
    // R1/R10: sweep the whole port space
    for (int a = 0; a < 256; a++) io_rd(a, 1, "R10");
    io_rd(8'h40, 3, "R1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule